// File: doc/BRIEF.md
# Mode-Configurable Registered Bus Transceiver

This block moves 8-bit data in two directions between a split A side and a shared bidirectional B side. Words arriving on `aIn` go out on the B bus. Words on the B bus come back out on `aOut`. The data is never inverted. Each direction has its own storage element. A 2-bit mode selects how that element behaves: it can pass data straight through, capture it on a rising edge of its gate, or act as a transparent latch whose gate works as an active-high enable. The mode can be changed while the block runs.

A loopback control feeds the B-to-A element from the A-to-B element's output instead of the B bus. Software can then watch on `aOut` what the block is driving toward B, which is useful for diagnostics. The A output has one active-high enable. The B bus is driven only when both of its enables agree. Both storage elements keep loading and holding data while their outputs are disabled.

The block runs from a single system clock `clk`. The direction gates `abGate` and `baGate` are inputs synchronous to `clk`. A rising edge of a gate is taken to be a low sample followed by a high sample on consecutive `clk` rising edges. A latch-mode element is transparent for as long as its gate input is high. When the gate is low, the element shows the word it sampled on the last `clk` edge at which the gate was high.

Top module: `cfg_xcvr_top`

## Requirements
- R1: In buffer mode, the element's output equals its input in the same cycle, with no register stage. On the A-to-B path, `aIn` appears unchanged on `bBus`. On the B-to-A path, the element's input appears unchanged on `aOut`.
- R2: Each direction has its own 2-bit mode (`abMode`, `baMode`). The codes are 2'b00 = buffer, 2'b01 = edge-capture flip-flop, 2'b10 = transparent latch, and 2'b11 = buffer, the same as 2'b00.
- R3: In flip-flop mode, the element stores its input on the `clk` edge at which the gate is sampled high after having been sampled low on the previous edge. The output shows the stored word from the next cycle on. At all other times the output holds.
- R4: In latch mode, the output follows the input in the same cycle while the gate is high. The stored word is the input at the last `clk` edge with the gate high, and the output holds that word while the gate is low.
- R5: When `loopBack` is 0, the B-to-A element's input is the value on the `bBus` pins. When `loopBack` is 1, that input is the A-to-B element's output, whatever the mode of either element.
- R6: `aOutEn` equals `oeBa`. While `oeBa` is 0, `aOut` reads all zeros.
- R7: The block drives `bBus` with the A-to-B element's output only when `oeAbHi` = 1 and `oeAbLoN` = 0. For the other three combinations, `bBus` is left at high impedance.
- R8: Storage in both elements keeps loading and holding while `aOut` or `bBus` is disabled. A word captured while an output is disabled appears once that output is enabled.
- R9: A synchronous active-low `rstN` clears both stored words to zero and clears the recorded gate history. A gate that is high in the first cycle after reset therefore counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all storage updates on its rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| abMode | input | 2 | A-to-B element mode |
| baMode | input | 2 | B-to-A element mode |
| abGate | input | 1 | A-to-B capture gate / latch enable |
| baGate | input | 1 | B-to-A capture gate / latch enable |
| loopBack | input | 1 | 1 = B-to-A element is fed from the A-to-B element |
| oeBa | input | 1 | A output enable, active high |
| oeAbHi | input | 1 | B bus enable, active high |
| oeAbLoN | input | 1 | B bus enable, active low |
| aIn | input | 8 | A-side input data |
| aOut | output | 8 | A-side output data, zero when disabled |
| aOutEn | output | 1 | A-side drive enable |
| bBus | inout | 8 | Bidirectional B bus |

## Verification
A stored word that is wrong, or an edge history that is wrong, is invisible while its element is transparent. It shows up on `aOut` or `bBus` in the first cycle in which that element is in flip-flop mode, or in latch mode with its gate low, and its output is enabled. If a capture is missed or extra, the output differs from the cycle after the gate edge. The sweep covers every pair of modes with loopback both off and on. It moves the gates, the enables and the data every cycle and compares both outputs in every cycle. A stale word is therefore caught within a few cycles of the point where it goes wrong.

// File: rtl/cfg_xcvr_pkg.sv
package cfg_xcvr_pkg;

  localparam int NUM_DIRS = 2;
  localparam int DIR_AB   = 0;
  localparam int DIR_BA   = 1;

  typedef enum logic [1:0] {
    MODE_BUF     = 2'b00,
    MODE_FLOP    = 2'b01,
    MODE_LATCH   = 2'b10,
    MODE_BUF_ALT = 2'b11
  } elem_mode_e;

  // Strobes from control to one storage element.
  typedef struct packed {
    logic load;  // write the storage register at this clk edge
    logic pass;  // output follows the input combinationally
  } elem_strobe_t;

endpackage

// File: rtl/cfg_xcvr_ctrl.sv
module cfg_xcvr_ctrl
  import cfg_xcvr_pkg::*;
#(
  parameter int DIRS = NUM_DIRS
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [DIRS-1:0][1:0]          modeSel,
  input  logic [DIRS-1:0]               gateIn,
  output elem_strobe_t [DIRS-1:0]       strobes
);

  for (genvar g = 0; g < DIRS; g++) begin : g_dir
    logic gatePrev;
    logic gateRise;
    elem_mode_e mode;

    assign mode     = elem_mode_e'(modeSel[g]);
    assign gateRise = gateIn[g] & ~gatePrev;

    always_ff @(posedge clk) begin
      if (!rstN) gatePrev <= 1'b0;
      else       gatePrev <= gateIn[g];
    end

    always_comb begin
      strobes[g] = '{load: 1'b0, pass: 1'b1};
      unique case (mode)
        MODE_FLOP: begin
          strobes[g].load = gateRise;
          strobes[g].pass = 1'b0;
        end
        MODE_LATCH: begin
          strobes[g].load = gateIn[g];
          strobes[g].pass = gateIn[g];
        end
        default: begin
          strobes[g].load = 1'b0;
          strobes[g].pass = 1'b1;
        end
      endcase
    end

    // R3: a flip-flop capture cannot repeat on the very next edge
    assert_single_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
      (mode == MODE_FLOP && strobes[g].load) |=> !(mode == MODE_FLOP && strobes[g].load));
  end

endmodule

// File: rtl/cfg_xcvr_elem.sv
module cfg_xcvr_elem
  import cfg_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  elem_strobe_t     stb,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stored;

  always_ff @(posedge clk) begin
    if (!rstN)         stored <= '0;
    else if (stb.load) stored <= dIn;
  end

  assign dOut = stb.pass ? dIn : stored;

  // R9: after a reset edge the element shows zero unless it is transparent
  assert_reset_clear_R9: assert property (@(posedge clk)
    !rstN |=> (stb.pass || dOut == '0));

  // R4: with no load and no pass the output holds into the next opaque cycle
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.pass && !stb.load) |=> (stb.pass || $stable(dOut)));

endmodule

// File: rtl/cfg_xcvr_top.sv
module cfg_xcvr_top
  import cfg_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       abMode,
  input  logic [1:0]       baMode,
  input  logic             abGate,
  input  logic             baGate,
  input  logic             loopBack,
  input  logic             oeBa,
  input  logic             oeAbHi,
  input  logic             oeAbLoN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOutEn,
  inout  wire  [WIDTH-1:0] bBus
);

  elem_strobe_t [NUM_DIRS-1:0] strobes;
  logic [WIDTH-1:0] abVal;
  logic [WIDTH-1:0] baVal;
  logic [WIDTH-1:0] baSrc;
  logic             bDrive;

  cfg_xcvr_ctrl #(.DIRS(NUM_DIRS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel ({baMode, abMode}),
    .gateIn  ({baGate, abGate}),
    .strobes (strobes)
  );

  cfg_xcvr_elem #(.WIDTH(WIDTH)) u_elemAb (
    .clk  (clk),
    .rstN (rstN),
    .stb  (strobes[DIR_AB]),
    .dIn  (aIn),
    .dOut (abVal)
  );

  assign baSrc = loopBack ? abVal : bBus;

  cfg_xcvr_elem #(.WIDTH(WIDTH)) u_elemBa (
    .clk  (clk),
    .rstN (rstN),
    .stb  (strobes[DIR_BA]),
    .dIn  (baSrc),
    .dOut (baVal)
  );

  assign bDrive = oeAbHi & ~oeAbLoN;
  assign bBus   = bDrive ? abVal : {WIDTH{1'bz}};
  assign aOutEn = oeBa;
  assign aOut   = oeBa ? baVal : '0;

  // R1: buffer codes pass A input straight to the A-to-B output
  assert_buffer_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    (abMode == MODE_BUF || abMode == MODE_BUF_ALT) |-> abVal == aIn);

  // R3: a rising gate in flip-flop mode shows the captured word next cycle
  assert_flop_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    (abMode == MODE_FLOP && $rose(abGate)) |=> (abMode != MODE_FLOP || abVal == $past(aIn)));

  // R4: open latch is transparent
  assert_latch_open_R4: assert property (@(posedge clk) disable iff (!rstN)
    (abMode == MODE_LATCH && abGate) |-> abVal == aIn);

  // R5: loopback with a buffering B-to-A element mirrors the A-to-B output
  assert_loopback_R5: assert property (@(posedge clk) disable iff (!rstN)
    (loopBack && oeBa && (baMode == MODE_BUF || baMode == MODE_BUF_ALT)) |-> aOut == abVal);

  // R7: an enabled B bus carries the A-to-B element output
  assert_b_drive_R7: assert property (@(posedge clk) disable iff (!rstN)
    (oeAbHi && !oeAbLoN) |-> bBus == abVal);

endmodule

// File: tb/sim_cfg_xcvr_top.sv
`timescale 1ns/1ps
module sim_cfg_xcvr_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] abMode = 2'b00;
  logic [1:0] baMode = 2'b00;
  logic       abGate = 1'b0;
  logic       baGate = 1'b0;
  logic       loopBack = 1'b0;
  logic       oeBa = 1'b0;
  logic       oeAbHi = 1'b0;
  logic       oeAbLoN = 1'b1;
  logic [7:0] aIn = 8'h00;
  logic [7:0] aOut;
  logic       aOutEn;
  wire  [7:0] bBus;
  logic [7:0] tbB = 8'h00;
  logic       tbDrv;

  int totalCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  // bench-side model state
  logic [7:0] abSt = 8'h00, baSt = 8'h00;
  logic       abPrev = 1'b0, baPrev = 1'b0;

  always #2.5 clk = ~clk;

  assign tbDrv = !(oeAbHi && !oeAbLoN);
  assign bBus  = tbDrv ? tbB : 8'hzz;

  cfg_xcvr_top #(.WIDTH(8)) u0 (
    .clk(clk), .rstN(rstN), .abMode(abMode), .baMode(baMode),
    .abGate(abGate), .baGate(baGate), .loopBack(loopBack),
    .oeBa(oeBa), .oeAbHi(oeAbHi), .oeAbLoN(oeAbLoN),
    .aIn(aIn), .aOut(aOut), .aOutEn(aOutEn), .bBus(bBus)
  );

  function automatic logic [7:0] elemOut(input logic [1:0] m, input logic g,
                                         input logic [7:0] din, input logic [7:0] st);
    if (m == 2'b01)      return st;
    else if (m == 2'b10) return g ? din : st;
    else                 return din;
  endfunction

  task automatic expVals(output logic [7:0] abV, output logic [7:0] baIn,
                         output logic [7:0] baV);
    logic [7:0] bSeen;
    abV   = elemOut(abMode, abGate, aIn, abSt);
    bSeen = tbDrv ? tbB : abV;
    baIn  = loopBack ? abV : bSeen;
    baV   = elemOut(baMode, baGate, baIn, baSt);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clk edge, model advanced with the inputs held across it
  task automatic cyc();
    logic [7:0] abV, baIn, baV;
    @(posedge clk);
    expVals(abV, baIn, baV);
    if (!rstN) begin
      abSt = 8'h00; baSt = 8'h00; abPrev = 1'b0; baPrev = 1'b0;
    end else begin
      if ((abMode == 2'b01 && abGate && !abPrev) || (abMode == 2'b10 && abGate)) abSt = aIn;
      if ((baMode == 2'b01 && baGate && !baPrev) || (baMode == 2'b10 && baGate)) baSt = baIn;
      abPrev = abGate; baPrev = baGate;
    end
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0; abGate = 1'b0; baGate = 1'b0;
    cyc(); cyc();
    rstN = 1'b1;
  endtask

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", totalCnt - failCnt, totalCnt);
  endtask

  initial begin
    logic [7:0] abV, baIn, baV;
    #1;
    // directed: reset state and activity while outputs disabled
    abMode = 2'b01; baMode = 2'b01; loopBack = 1'b0;
    doReset();
    oeBa = 1'b1; oeAbHi = 1'b1; oeAbLoN = 1'b0; aIn = 8'h77;
    #1;
    chk("R9 B after reset", bBus, 8'h00);
    chk("R9 A after reset", aOut, 8'h00);
    oeBa = 1'b0; oeAbHi = 1'b0; tbB = 8'h5A; aIn = 8'h3C;
    abGate = 1'b1; baGate = 1'b1;
    cyc();
    chk("R6 A disabled reads zero", aOut, 8'h00);
    chk("R6 A enable low", {7'd0, aOutEn}, 8'h00);
    abGate = 1'b0; baGate = 1'b0; tbB = 8'hC3; aIn = 8'h81;
    cyc();
    oeBa = 1'b1; oeAbHi = 1'b1;
    #1;
    chk("R8 A word captured while disabled", aOut, 8'h5A);
    chk("R8 B word captured while disabled", bBus, 8'h3C);
    chk("R6 A enable high", {7'd0, aOutEn}, 8'h01);

    // sweep every mode pair with loopback off and on
    for (int am = 0; am < 4; am++) begin
      for (int bm = 0; bm < 4; bm++) begin
        for (int lb = 0; lb < 2; lb++) begin
          int c;
          c = am * 8 + bm * 2 + lb;
          abMode = 2'(am); baMode = 2'(bm); loopBack = lb[0];
          doReset();
          for (int k = 0; k < 14; k++) begin
            logic [1:0] oeSel;
            aIn    = 8'(k * 37 + c * 11 + 5);
            tbB    = 8'(k * 53 + c * 7 + 129);
            abGate = (k % 3 == 1) || (k % 7 == 4);
            baGate = (k % 4) >= 2;
            oeBa   = (k % 5) != 0;
            oeSel  = 2'(k + c);
            oeAbHi = oeSel[0]; oeAbLoN = oeSel[1];
            #1;
            expVals(abV, baIn, baV);
            chk("R6 enable follows oeBa", {7'd0, aOutEn}, {7'd0, oeBa});
            if (oeBa)
              chk(lb ? "R5 loopback A output" : modeTag(2'(bm)), aOut, baV);
            else
              chk("R6 A disabled reads zero", aOut, 8'h00);
            if (!tbDrv)
              chk(am == 3 ? "R2 B output" : "R7 B output", bBus, abV);
            cyc();
          end
        end
      end
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      totalCnt++; failCnt++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

endmodule